// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host-side sequencer for a three-wire serial analog-to-digital converter. On a `start` request it drives the active-low conversion-start line low for a fixed number of system clocks. It then waits for the converter's busy line to rise and fall again. After that it produces exactly sixteen serial clock pulses, derived from the system clock by a divider.

Each bit on the data line is captured in the last system clock of the serial clock's high phase. That point lies just before the falling edge on which the converter changes the bit, so the full serial clock period is available for data access. The sixteen-bit frame opens with four bits that must be zero. The twelve bits after them form the result, most significant bit first.

The result is presented with a one-cycle valid strobe and a flag that reports a non-zero leading bit. The serial clock stays low at every other time, and in particular while conversion-start falls.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `convst_n` is 1, `sclk` is 0 and `result_valid` is 0 until `start` is seen.
- R2: A `start` sampled high while the controller is idle drives `convst_n` low for exactly `CONV_LEN` system clocks. A `start` sampled at any other time is ignored and causes no further conversion.
- R3: No rising edge of `sclk` occurs while `busy` is high. A read begins only after `busy`, passed through a two-flop synchronizer, has been seen high and then low.
- R4: Each read produces exactly 16 rising edges of `sclk`. `sclk` then stays low until the next read.
- R5: Every high phase and every low phase of `sclk` inside a read lasts exactly HALF_EFF system clocks. HALF_EFF is the larger of `HALF_DIV` and ceil(`MIN_HALF_NS`/`CLK_NS`). With `CLK_NS`=10 and `MIN_HALF_NS`=40, this is at least 4.
- R6: `sclk` is 0 whenever `convst_n` falls, and `convst_n` never falls while `sclk` is high or while a read is in progress.
- R7: `sdata` is sampled in the last system clock of each `sclk` high phase. The frame is 16 bits, first received bit first. `result` equals the last 12 received bits, with the first of them as bit 11.
- R8: `result_valid` is high for exactly one system clock after the 16th `sclk` falling edge. `result` holds its value until the next conversion starts.
- R9: `frame_err` is high together with `result_valid` exactly when any of the first four received bits is 1, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion and read |
| busy | input | 1 | Converter busy flag, asynchronous |
| sdata | input | 1 | Serial data from the converter |
| convst_n | output | 1 | Active-low conversion-start pulse |
| sclk | output | 1 | Serial clock to the converter |
| result | output | FRAME_BITS-LEAD_BITS | Twelve-bit conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| frame_err | output | 1 | A leading bit was non-zero, valid with the strobe |

## Verification
The converter model replays sixteen-bit frames in which the first bit is driven on the first rising edge and every later bit on a falling edge. The frames use all-zero, all-one, alternating, single-end-bit and mixed result words. A bit-order or sample-point mistake shifts or mirrors these words in ways that can be told apart. Frames with a non-zero leading bit at either end of the leading nibble separate a missing error flag from one that looks at the wrong bits. Further `start` pulses issued while busy is high and in the middle of the shift phase show whether a second conversion would fire. The phase widths are measured with a divider setting below the 40 ns minimum, which shows whether the floor is enforced.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_DONE  = 3'd4
    } rd_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock divider: low half, then high half, repeated NPULSE times.
module adc_sclk_gen #(
    parameter int HALF   = 4,
    parameter int NPULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic sample_stb,
    output logic last_stb
);
    localparam int CW = $clog2(HALF + 1);
    localparam int PW = $clog2(NPULSE + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
        logic [PW-1:0] pulses;
    } gen_s;

    gen_s gen_q, gen_d;
    logic half_end;

    always_comb begin
        half_end   = (gen_q.cnt == CW'(HALF - 1));
        sample_stb = run && half_end && gen_q.sclk;
        last_stb   = sample_stb && (gen_q.pulses == PW'(NPULSE - 1));
        gen_d      = gen_q;
        if (!run) begin
            gen_d = '0;
        end else if (half_end) begin
            gen_d.cnt  = '0;
            gen_d.sclk = !gen_q.sclk;
            if (gen_q.sclk) begin
                gen_d.pulses = gen_q.pulses + 1'b1;
            end
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk = gen_q.sclk;

endmodule

// File: rtl/adc_shift_rx.sv
// Frame capture register, first bit lands at the top.
module adc_shift_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] word_q, word_d;

    always_comb begin
        word_d = word_q;
        if (clr) begin
            word_d = '0;
        end else if (stb) begin
            word_d = {word_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int HALF_DIV    = 5,
    parameter int MIN_HALF_NS = 40,
    parameter int CONV_LEN    = 4,
    parameter int FRAME_BITS  = 16,
    parameter int LEAD_BITS   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           busy,
    input  logic                           sdata,
    output logic                           convst_n,
    output logic                           sclk,
    output logic [FRAME_BITS-LEAD_BITS-1:0] result,
    output logic                           result_valid,
    output logic                           frame_err
);
    localparam int RES_BITS     = FRAME_BITS - LEAD_BITS;
    localparam int MIN_HALF_CYC = (MIN_HALF_NS + CLK_NS - 1) / CLK_NS;
    localparam int HALF_EFF     = (HALF_DIV > MIN_HALF_CYC) ? HALF_DIV : MIN_HALF_CYC;
    localparam int CCW          = $clog2(CONV_LEN + 1);

    typedef struct packed {
        rd_state_e      state;
        logic [CCW-1:0] cnt;
        logic           seen;
        logic [1:0]     bsync;
        logic           convst_n;
    } ctl_s;

    localparam ctl_s CTL_RST = '{state: ST_IDLE, cnt: '0, seen: 1'b0,
                                 bsync: 2'b00, convst_n: 1'b1};

    ctl_s ctl_q, ctl_d;

    logic                  run;
    logic                  sample_stb;
    logic                  last_stb;
    logic                  busy_s;
    logic [FRAME_BITS-1:0] word;

    assign busy_s = ctl_q.bsync[1];
    assign run    = (ctl_q.state == ST_SHIFT);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.bsync = {ctl_q.bsync[0], busy};
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_CONV;
                    ctl_d.cnt   = '0;
                    ctl_d.seen  = 1'b0;
                end
            end
            ST_CONV: begin
                if (busy_s) begin
                    ctl_d.seen = 1'b1;
                end
                if (ctl_q.cnt == CCW'(CONV_LEN - 1)) begin
                    ctl_d.state = ST_WAIT;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (busy_s) begin
                    ctl_d.seen = 1'b1;
                end else if (ctl_q.seen) begin
                    ctl_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_stb) begin
                    ctl_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
        ctl_d.convst_n = (ctl_d.state != ST_CONV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    adc_sclk_gen #(
        .HALF   (HALF_EFF),
        .NPULSE (FRAME_BITS)
    ) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sclk       (sclk),
        .sample_stb (sample_stb),
        .last_stb   (last_stb)
    );

    adc_shift_rx #(
        .W (FRAME_BITS)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl_q.state == ST_CONV),
        .stb   (sample_stb),
        .din   (sdata),
        .word  (word)
    );

    assign convst_n     = ctl_q.convst_n;
    assign result_valid = (ctl_q.state == ST_DONE);
    assign result       = word[RES_BITS-1:0];
    assign frame_err    = result_valid && (|word[FRAME_BITS-1 -: LEAD_BITS]);

endmodule

module adc_rd_ctrl_chk #(
    parameter int HALF_EFF = 4,
    parameter int NPULSE   = 16
) (
    input logic clk,
    input logic rst_n,
    input logic convst_n,
    input logic sclk,
    input logic busy,
    input logic result_valid,
    input logic frame_err
);
    logic        sclk_prev;
    logic [15:0] hi_len;
    logic [15:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            hi_len    <= '0;
            pcnt      <= '0;
        end else begin
            sclk_prev <= sclk;
            hi_len    <= sclk ? hi_len + 16'd1 : 16'd0;
            if (!convst_n) begin
                pcnt <= '0;
            end else if (sclk && !sclk_prev) begin
                pcnt <= pcnt + 16'd1;
            end
        end
    end

    AST_SCLK_LOW_AT_CONVST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_n) |-> !sclk); // R6
    AST_NO_CONVST_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> convst_n); // R6
    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !sclk_prev) |-> (pcnt < 16'(NPULSE))); // R4
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == 16'(HALF_EFF))); // R5
    AST_SCLK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !busy); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R8
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> result_valid); // R9

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .HALF_EFF (HALF_EFF),
    .NPULSE   (FRAME_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .convst_n     (convst_n),
    .sclk         (sclk),
    .busy         (busy),
    .result_valid (result_valid),
    .frame_err    (frame_err)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int CONV_LEN   = 3;
    localparam int BUSY_CYC   = 20;
    localparam int HALF_EFF   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy = 1'b0;
    logic        sdata = 1'b0;
    logic        convst_n;
    logic        sclk;
    logic [11:0] result;
    logic        result_valid;
    logic        frame_err;

    int checks = 0;
    int errors = 0;
    int n_sent = 0;
    int n_got = 0;
    int conv_falls = 0;
    int sclk_viol = 0;
    int busy_viol = 0;
    int frame_rises = 0;
    logic [15:0] m_word = '0;
    logic [12:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_rd_ctrl #(
        .CLK_NS      (CLK_PERIOD),
        .HALF_DIV    (HALF_DIV),
        .MIN_HALF_NS (40),
        .CONV_LEN    (CONV_LEN),
        .FRAME_BITS  (16),
        .LEAD_BITS   (4)
    ) u_adc_rd_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy         (busy),
        .sdata        (sdata),
        .convst_n     (convst_n),
        .sclk         (sclk),
        .result       (result),
        .result_valid (result_valid),
        .frame_err    (frame_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Converter model: busy handling
    always @(negedge convst_n) begin
        conv_falls++;
        if (sclk) sclk_viol++;
        #3 busy = 1'b1;
        repeat (BUSY_CYC) @(posedge clk);
        #3 busy = 1'b0;
    end

    // Converter model: serial data
    initial begin
        logic cv_prev = 1'b1;
        logic sk_prev = 1'b0;
        bit   driving = 1'b0;
        int   nf = 0;
        forever begin
            @(convst_n or sclk);
            #2;
            if (cv_prev && !convst_n) begin
                nf = 0;
                driving = 1'b0;
                sdata = 1'b0;
            end else if (!sk_prev && sclk) begin
                if (busy) busy_viol++;
                if (!driving) begin
                    driving = 1'b1;
                    sdata = m_word[15];
                end
            end else if (sk_prev && !sclk) begin
                nf++;
                sdata = (nf < 16) ? m_word[15-nf] : 1'b0;
            end
            cv_prev = convst_n;
            sk_prev = sclk;
        end
    end

    // Phase width and conversion pulse monitor
    initial begin
        logic sk_s = 1'b0;
        int hi_cnt = 0;
        int lo_cnt = 0;
        int cl_cnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!convst_n) begin
                    cl_cnt++;
                    frame_rises = 0;
                end else if (cl_cnt != 0) begin
                    chk(cl_cnt == CONV_LEN, "R2 convst_n low width", cl_cnt, CONV_LEN);
                    cl_cnt = 0;
                end
                if (sclk) begin
                    if (!sk_s) begin
                        if (frame_rises > 0)
                            chk(lo_cnt == HALF_EFF, "R5 sclk low width", lo_cnt, HALF_EFF);
                        frame_rises++;
                        hi_cnt = 0;
                    end
                    hi_cnt++;
                end else begin
                    if (sk_s) begin
                        chk(hi_cnt == HALF_EFF, "R5 sclk high width", hi_cnt, HALF_EFF);
                        lo_cnt = 0;
                    end
                    lo_cnt++;
                end
                sk_s = sclk;
            end
        end
    end

    // Scoreboard monitor
    initial begin
        logic prev_valid = 1'b0;
        logic [12:0] e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_valid)
                    chk(!result_valid, "R8 result_valid one cycle", int'(result_valid), 0);
                if (!result_valid)
                    chk(!frame_err, "R9 frame_err outside strobe", int'(frame_err), 0);
                if (result_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected result", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(result == e[11:0], "R7 result", int'(result), int'(e[11:0]));
                        chk(frame_err == e[12], "R9 frame_err", int'(frame_err), int'(e[12]));
                        chk(frame_rises == 16, "R4 sclk pulses per read", frame_rises, 16);
                    end
                    n_got++;
                end
                prev_valid = result_valid;
            end
        end
    end

    task automatic do_read(input logic [3:0] lead, input logic [11:0] val, input bit poke);
        m_word = {lead, val};
        exp_q.push_back({|lead, val});
        n_sent++;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            wait (sclk == 1'b1);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wait (n_got == n_sent);
        repeat (2) @(negedge clk);
        chk(result == val, "R8 result held after strobe", int'(result), int'(val));
        repeat (20) @(negedge clk);
        chk(sclk == 1'b0, "R4 sclk idle low after read", int'(sclk), 0);
        chk(frame_rises == 16, "R4 no extra pulses after read", frame_rises, 16);
        chk(conv_falls == n_sent, "R2 one conversion per accepted start", conv_falls, n_sent);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired act=%0d exp=%0d", n_got, n_sent);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(convst_n == 1'b1, "R1 convst_n in reset", int'(convst_n), 1);
        chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
        chk(result_valid == 1'b0, "R1 result_valid in reset", int'(result_valid), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(convst_n == 1'b1 && sclk == 1'b0, "R1 idle without start",
            int'({convst_n, sclk}), 2);
        chk(conv_falls == 0, "R1 no conversion without start", conv_falls, 0);

        do_read(4'h0, 12'hA5C, 1'b0);
        do_read(4'h0, 12'h000, 1'b0);
        do_read(4'h0, 12'hFFF, 1'b0);
        do_read(4'h0, 12'h801, 1'b0);
        do_read(4'h0, 12'h001, 1'b1);
        do_read(4'h8, 12'h3C6, 1'b0);
        do_read(4'h1, 12'h555, 1'b0);
        do_read(4'h0, 12'hAAA, 1'b1);

        chk(busy_viol == 0, "R3 sclk rise while busy", busy_viol, 0);
        chk(sclk_viol == 0, "R6 sclk high at convst_n fall", sclk_viol, 0);
        chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule